// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small single-bus processor. The control signals are not produced by hardwired state logic. Each clock cycle, a micro-program counter selects one word of an internal control store. The control-signal field of that word is driven straight onto the control-word output, where it steers the register transfers of the datapath for that cycle.

Every word also says how the next micro-address is formed. It can step to the following word, dispatch through a starting-address generator that maps the opcode to the first word of that instruction's routine, branch to a target when a selected condition flag is set, or go back to the shared fetch routine at address 0. A word that carries the wait-for-memory bit holds the micro-PC until the memory-done input is high. A word that carries the end bit always returns the sequencer to fetch.

The datapath and the memory sit outside the block. The opcode input stands for the instruction register contents and must be stable when the third fetch word is current.

Top module: `useq_top`

## Requirements
- R1: The control word bit map is: 0 PC to bus, 1 load PC, 2 load MAR, 3 MDR to bus, 4 load IR, 5 load Y, 6 clear Y, 7 load R1, 8 R1 to bus, 9 R3 to bus, 10 load Z, 11 Z to bus, 12 ALU add, 13 ALU carry-in, 14 memory read, 15 wait for memory, 16 end.
- R2: The fetch routine runs three words from address 0, in this order:
  - PC to bus, load MAR, read, clear Y, carry-in, add, load Z.
  - Z to bus, load PC, wait.
  - MDR to bus, load IR.
- R3: After the third fetch word the next micro-address comes from the opcode present on that cycle.
- R4: While the current word has the wait bit set and mem_done is low, the control word stays unchanged. The routine advances on the first cycle that has mem_done high.
- R5: Opcode dispatch works as follows:
  - Opcode 1 enters the register-indirect add routine.
  - Opcode 2 enters a routine that tests flag 0.
  - Opcode 3 enters a routine that tests flag 3.
  - Every other opcode enters the end-only routine.
- R6: The register-indirect add routine runs four words in this order:
  - R3 to bus, load MAR, read.
  - R1 to bus, load Y, wait.
  - MDR to bus, add, load Z.
  - Z to bus, load R1, end.
- R7: The two flag-test routines behave as follows:
  - Each starts with a word that has all control bits clear.
  - Opcode 2 then gives R1 to bus, load Y, end when flag 0 is set, and R3 to bus, load Y, end when it is clear.
  - Opcode 3 then gives Z to bus, load PC, end when flag 3 is set, and PC to bus, load Y, end when it is clear.
  - No other flag affects either routine.
- R8: On the cycle after a word with the end bit, the control word is the first fetch word.
- R9: No word drives more than one source onto the bus. The sources are PC, MDR, R1, R3 and Z.
- R10: An unmapped opcode produces exactly one word, with only the end bit set, before fetch resumes.
- R11: Asserting rst_n low forces the first fetch word at once. The micro-PC stays at address 0 for two rising edges after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| opcode | input | 4 | Instruction register opcode used for dispatch |
| cond_flags | input | 4 | Status flags and condition codes tested by branch words |
| mem_done | input | 1 | Memory function complete |
| ctrl_word | output | 17 | Register-transfer control signals for the current cycle |

## Verification
The hardest situation to reach is a stall that lasts several cycles on a wait word inside an instruction routine, as opposed to the fetch routine. The micro-PC must hold there and then resume in exactly the right cycle. The stimulus keeps mem_done low for a chosen number of cycles at both the second fetch word and the second add word, and it raises mem_done in the window before the edge that should release the stall. The flag-test routines are run with the tested flag clear while every other flag is set, so that a wrong flag selection shows up as a wrong final word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CW_W   = 17;
  localparam int UA_W   = 5;
  localparam int OPC_W  = 4;
  localparam int FLG_W  = 4;
  localparam int FSEL_W = $clog2(FLG_W);

  // control bit positions
  localparam int CB_PC_OUT  = 0;
  localparam int CB_PC_IN   = 1;
  localparam int CB_MAR_IN  = 2;
  localparam int CB_MDR_OUT = 3;
  localparam int CB_IR_IN   = 4;
  localparam int CB_Y_IN    = 5;
  localparam int CB_Y_CLR   = 6;
  localparam int CB_R1_IN   = 7;
  localparam int CB_R1_OUT  = 8;
  localparam int CB_R3_OUT  = 9;
  localparam int CB_Z_IN    = 10;
  localparam int CB_Z_OUT   = 11;
  localparam int CB_ADD     = 12;
  localparam int CB_CIN     = 13;
  localparam int CB_READ    = 14;
  localparam int CB_WAIT    = 15;
  localparam int CB_END     = 16;

  localparam logic [CW_W-1:0] M_PC_OUT  = CW_W'(1) << CB_PC_OUT;
  localparam logic [CW_W-1:0] M_PC_IN   = CW_W'(1) << CB_PC_IN;
  localparam logic [CW_W-1:0] M_MAR_IN  = CW_W'(1) << CB_MAR_IN;
  localparam logic [CW_W-1:0] M_MDR_OUT = CW_W'(1) << CB_MDR_OUT;
  localparam logic [CW_W-1:0] M_IR_IN   = CW_W'(1) << CB_IR_IN;
  localparam logic [CW_W-1:0] M_Y_IN    = CW_W'(1) << CB_Y_IN;
  localparam logic [CW_W-1:0] M_Y_CLR   = CW_W'(1) << CB_Y_CLR;
  localparam logic [CW_W-1:0] M_R1_IN   = CW_W'(1) << CB_R1_IN;
  localparam logic [CW_W-1:0] M_R1_OUT  = CW_W'(1) << CB_R1_OUT;
  localparam logic [CW_W-1:0] M_R3_OUT  = CW_W'(1) << CB_R3_OUT;
  localparam logic [CW_W-1:0] M_Z_IN    = CW_W'(1) << CB_Z_IN;
  localparam logic [CW_W-1:0] M_Z_OUT   = CW_W'(1) << CB_Z_OUT;
  localparam logic [CW_W-1:0] M_ADD     = CW_W'(1) << CB_ADD;
  localparam logic [CW_W-1:0] M_CIN     = CW_W'(1) << CB_CIN;
  localparam logic [CW_W-1:0] M_READ    = CW_W'(1) << CB_READ;
  localparam logic [CW_W-1:0] M_WAIT    = CW_W'(1) << CB_WAIT;
  localparam logic [CW_W-1:0] M_END     = CW_W'(1) << CB_END;

  // routine entry points
  localparam logic [UA_W-1:0] UA_FETCH  = UA_W'(0);
  localparam logic [UA_W-1:0] UA_ADDIND = UA_W'(4);
  localparam logic [UA_W-1:0] UA_TST_A  = UA_W'(8);
  localparam logic [UA_W-1:0] UA_TST_B  = UA_W'(11);
  localparam logic [UA_W-1:0] UA_NOP    = UA_W'(15);

  localparam logic [OPC_W-1:0] OP_ADDIND = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_TST_A  = OPC_W'(2);
  localparam logic [OPC_W-1:0] OP_TST_B  = OPC_W'(3);

  typedef enum logic [1:0] {
    NX_STEP     = 2'd0,
    NX_DISPATCH = 2'd1,
    NX_BRANCH   = 2'd2,
    NX_FETCH    = 2'd3
  } nx_mode_e;

  typedef struct packed {
    logic [CW_W-1:0]   ctrl;
    nx_mode_e          mode;
    logic [FSEL_W-1:0] fsel;
    logic [UA_W-1:0]   target;
  } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          uword
);
  localparam logic [CW_W-1:0] BUS_SRC = M_PC_OUT | M_MDR_OUT | M_R1_OUT | M_R3_OUT | M_Z_OUT;

  function automatic uword_t mk(input logic [CW_W-1:0] c, input nx_mode_e m,
                                input logic [FSEL_W-1:0] f, input logic [UA_W-1:0] t);
    uword_t w;
    w.ctrl   = c;
    w.mode   = m;
    w.fsel   = f;
    w.target = t;
    return w;
  endfunction

  always_comb begin
    case (addr)
      // fetch
      UA_W'(0):  uword = mk(M_PC_OUT | M_MAR_IN | M_READ | M_Y_CLR | M_CIN | M_ADD | M_Z_IN,
                            NX_STEP, '0, '0);
      UA_W'(1):  uword = mk(M_Z_OUT | M_PC_IN | M_WAIT, NX_STEP, '0, '0);
      UA_W'(2):  uword = mk(M_MDR_OUT | M_IR_IN, NX_DISPATCH, '0, '0);
      // register-indirect add
      UA_W'(4):  uword = mk(M_R3_OUT | M_MAR_IN | M_READ, NX_STEP, '0, '0);
      UA_W'(5):  uword = mk(M_R1_OUT | M_Y_IN | M_WAIT, NX_STEP, '0, '0);
      UA_W'(6):  uword = mk(M_MDR_OUT | M_ADD | M_Z_IN, NX_STEP, '0, '0);
      UA_W'(7):  uword = mk(M_Z_OUT | M_R1_IN | M_END, NX_FETCH, '0, '0);
      // flag 0 test
      UA_W'(8):  uword = mk('0, NX_BRANCH, FSEL_W'(0), UA_W'(10));
      UA_W'(9):  uword = mk(M_R3_OUT | M_Y_IN | M_END, NX_FETCH, '0, '0);
      UA_W'(10): uword = mk(M_R1_OUT | M_Y_IN | M_END, NX_FETCH, '0, '0);
      // flag 3 test
      UA_W'(11): uword = mk('0, NX_BRANCH, FSEL_W'(3), UA_W'(13));
      UA_W'(12): uword = mk(M_PC_OUT | M_Y_IN | M_END, NX_FETCH, '0, '0);
      UA_W'(13): uword = mk(M_Z_OUT | M_PC_IN | M_END, NX_FETCH, '0, '0);
      // unmapped opcodes and spare words
      default:   uword = mk(M_END, NX_FETCH, '0, '0);
    endcase
  end

  always_comb begin
    AST_BUS_ONE_DRIVER: assert ($onehot0(uword.ctrl & BUS_SRC)) else $error("bus contention"); // R9
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  start_addr
);
  always_comb begin
    case (opcode)
      OP_ADDIND: start_addr = UA_ADDIND;
      OP_TST_A:  start_addr = UA_TST_A;
      OP_TST_B:  start_addr = UA_TST_B;
      default:   start_addr = UA_NOP;
    endcase
  end

  always_comb begin
    AST_DISPATCH_NOT_FETCH: assert (start_addr != UA_FETCH) else $error("dispatch to fetch"); // R5
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [UA_W-1:0]   upc,
  input  logic              wait_bit,
  input  logic              end_bit,
  input  nx_mode_e          mode,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [UA_W-1:0]   target,
  input  logic [UA_W-1:0]   start_addr,
  input  logic [FLG_W-1:0]  cond_flags,
  input  logic              mem_done,
  output logic              stall,
  output logic [UA_W-1:0]   upc_nxt
);
  logic [UA_W-1:0] upc_inc;
  logic            flag_hit;

  assign upc_inc  = UA_W'(upc + 1'b1);
  assign flag_hit = cond_flags[fsel];
  assign stall    = wait_bit & ~mem_done;

  always_comb begin
    if (end_bit) begin
      upc_nxt = UA_FETCH;
    end else begin
      case (mode)
        NX_STEP:     upc_nxt = upc_inc;
        NX_DISPATCH: upc_nxt = start_addr;
        NX_BRANCH:   upc_nxt = flag_hit ? target : upc_inc;
        default:     upc_nxt = UA_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FLG_W-1:0] cond_flags,
  input  logic             mem_done,
  output logic [CW_W-1:0]  ctrl_word
);
  logic            rst_core_n;
  logic [UA_W-1:0] upc;
  logic [UA_W-1:0] upc_nxt;
  logic [UA_W-1:0] start_addr;
  logic            stall;
  logic            upc_en;
  uword_t          uw;

  // reset: asynchronous assertion, synchronous release
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] rst_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_core_n = rst_pipe[SYNC_STAGES-1];
    end else begin : g_sync1
      logic rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= 1'b1;
      end
      assign rst_core_n = rst_q;
    end
  endgenerate

  useq_store u_store (
    .addr  (upc),
    .uword (uw)
  );

  useq_dispatch u_dispatch (
    .opcode     (opcode),
    .start_addr (start_addr)
  );

  useq_next u_next (
    .upc        (upc),
    .wait_bit   (uw.ctrl[CB_WAIT]),
    .end_bit    (uw.ctrl[CB_END]),
    .mode       (uw.mode),
    .fsel       (uw.fsel),
    .target     (uw.target),
    .start_addr (start_addr),
    .cond_flags (cond_flags),
    .mem_done   (mem_done),
    .stall      (stall),
    .upc_nxt    (upc_nxt)
  );

  assign upc_en = ~stall;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  upc <= UA_FETCH;
    else if (upc_en)  upc <= upc_nxt;
  end

  assign ctrl_word = uw.ctrl;

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl_word[CB_WAIT] && !mem_done) |=> $stable(upc)) else $error("stall broken"); // R4
  AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl_word[CB_END] && !(ctrl_word[CB_WAIT] && !mem_done)) |=> (upc == UA_FETCH)) else $error("end"); // R8
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (uw.mode == NX_STEP && !ctrl_word[CB_END] && !stall) |=> (upc == UA_W'($past(upc) + 1'b1))) else $error("step"); // R2
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (uw.mode == NX_BRANCH && !ctrl_word[CB_END] && cond_flags[uw.fsel]) |=> (upc == $past(uw.target))) else $error("branch"); // R7
  AST_DISPATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (uw.mode == NX_DISPATCH && !stall) |=> (upc == $past(start_addr))) else $error("dispatch"); // R3
endmodule

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [3:0]  cond_flags;
  logic        mem_done;
  logic [16:0] ctrl_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  // expected words from the bit map of R1
  function automatic logic [16:0] b(input int i);
    return 17'(1) << i;
  endfunction
  localparam logic [16:0] W_F1  = b(0)|b(2)|b(14)|b(6)|b(13)|b(12)|b(10);
  localparam logic [16:0] W_F2  = b(11)|b(1)|b(15);
  localparam logic [16:0] W_F3  = b(3)|b(4);
  localparam logic [16:0] W_A1  = b(9)|b(2)|b(14);
  localparam logic [16:0] W_A2  = b(8)|b(5)|b(15);
  localparam logic [16:0] W_A3  = b(3)|b(12)|b(10);
  localparam logic [16:0] W_A4  = b(11)|b(7)|b(16);
  localparam logic [16:0] W_T0  = 17'd0;
  localparam logic [16:0] W_AHIT = b(8)|b(5)|b(16);
  localparam logic [16:0] W_AMIS = b(9)|b(5)|b(16);
  localparam logic [16:0] W_BHIT = b(11)|b(1)|b(16);
  localparam logic [16:0] W_BMIS = b(0)|b(5)|b(16);
  localparam logic [16:0] W_NOP = b(16);

  useq_top i_useq_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .cond_flags (cond_flags),
    .mem_done   (mem_done),
    .ctrl_word  (ctrl_word)
  );

  always #4 clk = ~clk;

  // monitor
  always @(negedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (ctrl_word !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, ctrl_word, e);
      end
    end
  end

  task automatic step(input logic [16:0] w, input logic done_v, input string t);
    @(negedge clk);
    mem_done = done_v;
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic run_instr(input logic [3:0] op, input logic [3:0] fl,
                           input int fw, input int rw);
    @(negedge clk);
    opcode = op; cond_flags = fl; mem_done = 1'b0;
    exp_q.push_back(W_F1); tag_q.push_back("R2 fetch1, R8 return");
    for (int i = 0; i < fw; i++) step(W_F2, 1'b0, "R4 fetch stall");
    step(W_F2, 1'b1, "R2 fetch2");
    step(W_F3, 1'b0, "R2 fetch3, R3 dispatch");
    case (op)
      4'd1: begin
        step(W_A1, 1'b0, "R6 add1, R5 entry");
        for (int i = 0; i < rw; i++) step(W_A2, 1'b0, "R4 routine stall");
        step(W_A2, 1'b1, "R6 add2, R9");
        step(W_A3, 1'b0, "R6 add3");
        step(W_A4, 1'b0, "R6 add4");
      end
      4'd2: begin
        step(W_T0, 1'b0, "R7 test A, R5 entry");
        step(fl[0] ? W_AHIT : W_AMIS, 1'b0, "R7 flag0 outcome");
      end
      4'd3: begin
        step(W_T0, 1'b0, "R7 test B, R5 entry");
        step(fl[3] ? W_BHIT : W_BMIS, 1'b0, "R7 flag3 outcome");
      end
      default: step(W_NOP, 1'b0, "R10 unmapped end only");
    endcase
  endtask

  initial begin
    rst_n = 1'b0; opcode = '0; cond_flags = '0; mem_done = 1'b0;
    step(W_F1, 1'b0, "R11 in reset, R1 bitmap");
    step(W_F1, 1'b0, "R11 in reset");
    @(negedge clk); rst_n = 1'b1;
    exp_q.push_back(W_F1); tag_q.push_back("R11 release hold");
    step(W_F1, 1'b0, "R11 release hold");

    run_instr(4'd1, 4'h0, 0, 0);
    run_instr(4'd1, 4'hF, 3, 2);
    run_instr(4'd2, 4'b0001, 1, 0);
    run_instr(4'd2, 4'b1110, 0, 0);
    run_instr(4'd3, 4'b1000, 0, 0);
    run_instr(4'd3, 4'b0111, 2, 0);
    run_instr(4'd0, 4'h0, 0, 0);
    run_instr(4'd9, 4'h5, 0, 0);
    run_instr(4'd15, 4'h0, 0, 0);
    run_instr(4'd1, 4'h0, 1, 4);

    // asynchronous reset during a stall
    step(W_F1, 1'b0, "R2 fetch1");
    step(W_F2, 1'b0, "R4 fetch stall");
    @(negedge clk); rst_n = 1'b0;
    exp_q.push_back(W_F1); tag_q.push_back("R11 async reset");

    @(negedge clk); @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule